// File: doc/BRIEF.md
# Two-phase scan subchain controller

This block masters a serial scan subchain over five wires. It drives two non-overlapping clock phases, a capture strobe, an update strobe and a serial data line. It also receives the serial bit the chain returns. All of the wire timing is derived from the fast system clock by a single tick counter. One scan period is 40 system cycles, built from a fixed schedule of 9, 1, 19, 1 and 10 ticks, so a 4 GHz-class core clock gives a nominal 100 MHz scan rate.

A command gives a chain length, a parallel vector to shift in, and two flags. One flag selects a capture pulse before shifting and the other an update pulse after it. The block walks the bits from the highest index down to index 0. For each bit it first samples the returned line, then drives the outgoing bit, then runs one phase cycle. When the operation ends, the gathered bits appear on a parallel output and a one-cycle completion pulse is raised. A new command can be accepted in that same completion cycle.

Top module: `scan2ph_ctrl`

## Requirements
- R1: After reset and whenever idle, `scan_phi2` is 1 and `scan_phi1`, `scan_rd`, `scan_wr`, `scan_si`, `busy` and `done` are 0. `dout` resets to all zeros.
- R2: A command is taken only at a clock edge where `busy` is 0, `start` is 1 and 1 <= `cmd_len` <= MAX_LEN. `busy` is 1 from the cycle after that edge. A `start` while busy, or one with a length of 0 or above MAX_LEN, changes nothing.
- R3: Each bit occupies 40 cycles, in this order: `scan_phi2` high for 9 cycles, both phases low for 1, `scan_phi1` high for 19, both low for 1, then `scan_phi2` high for 10. The two phases are never high together.
- R4: With `cmd_rd`=1, `scan_rd` is high for the first 80 busy cycles and then low for 40 cycles before the first bit begins. With `cmd_rd`=0, the first bit begins in the first busy cycle.
- R5: Bits run from index `cmd_len`-1 down to 0. During the 40 cycles of bit i, `scan_si` equals bit i of `cmd_din`. Outside the bit cycles, `scan_si` is 0.
- R6: Bit i of the result is the value on `scan_so` at the clock edge that begins bit i, which is the same edge at which `scan_si` takes bit i. The value is 1 only when the line reads 1.
- R7: With `cmd_wr`=1, after the last bit `scan_wr` is high for 80 cycles and then low for 40 cycles before completion.
- R8: `done` is a single-cycle pulse with `busy` low. It follows the final bit, or the write gap. `busy` lasts 40·`cmd_len` + 120·`cmd_rd` + 120·`cmd_wr` cycles.
- R9: `dout` changes only in the `done` cycle. Its bits at index `cmd_len` and above are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request |
| cmd_len | input | LEN_W | Chain length in bits |
| cmd_din | input | MAX_LEN | Vector to shift in |
| cmd_rd | input | 1 | Pulse capture strobe first |
| cmd_wr | input | 1 | Pulse update strobe last |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dout | output | MAX_LEN | Captured vector |
| scan_phi1 | output | 1 | Scan clock phase one |
| scan_phi2 | output | 1 | Scan clock phase two |
| scan_rd | output | 1 | Capture strobe |
| scan_wr | output | 1 | Update strobe |
| scan_si | output | 1 | Serial data to chain |
| scan_so | input | 1 | Serial data from chain |

## Verification
Two functions can fall in the same cycle: completion of one operation (publishing `dout` with `done`) and acceptance of the next command. The bench provokes this by holding `start` high across the whole operation, so the next command is taken in the `done` cycle itself. A per-cycle expected timeline, built in the bench from the requirements, is then compared on every cycle. The check confirms that the second operation's first bit starts at once and that the published vector belongs to the first operation. `scan_so` toggles pseudo-randomly each cycle, so a capture taken one edge early or late shows up as a wrong bit.

// File: rtl/scan2ph_pkg.sv
package scan2ph_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_HI,
      ST_RD_LO,
      ST_SHIFT,
      ST_WR_HI,
      ST_WR_LO
   } ctl_st_e;

   typedef enum logic [2:0] {
      SG_LEAD,
      SG_FALL,
      SG_PHI1,
      SG_RISE,
      SG_TAIL
   } seg_e;

   typedef struct packed {
      logic phi1;
      logic phi2;
      logic rd;
      logic wr;
   } pins_t;

   localparam pins_t PINS_IDLE = '{phi1: 1'b0, phi2: 1'b1, rd: 1'b0, wr: 1'b0};

   function automatic pins_t pins_of(ctl_st_e st, seg_e sg);
      pins_t p;
      logic  sh;
      sh     = (st == ST_SHIFT);
      p.phi1 = sh && (sg == SG_PHI1);
      p.phi2 = !(sh && (sg == SG_FALL || sg == SG_PHI1 || sg == SG_RISE));
      p.rd   = (st == ST_RD_HI);
      p.wr   = (st == ST_WR_HI);
      return p;
   endfunction

endpackage

// File: rtl/scan2ph_tick.sv
module scan2ph_tick #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/scan2ph_capture.sv
module scan2ph_capture #(
   parameter int MAX_LEN = 64,
   parameter int IDX_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [MAX_LEN-1:0] load_din,
   input  logic               cap_en,
   input  logic [IDX_W-1:0]   cap_idx,
   input  logic [IDX_W-1:0]   cur_idx,
   input  logic               shifting,
   input  logic               publish,
   input  logic               so,
   output logic               si,
   output logic [MAX_LEN-1:0] dout
);
   logic [MAX_LEN-1:0] din_q;
   logic [MAX_LEN-1:0] cap;
   logic [MAX_LEN-1:0] dout_q;
   logic               so_bit;

   assign so_bit = (so === 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    din_q <= '0;
      else if (load) din_q <= load_din;
   end

   for (genvar g = 0; g < MAX_LEN; g++) begin : g_cap
      logic hit;
      logic bit_q;
      assign hit = cap_en && (cap_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    bit_q <= 1'b0;
         else if (load) bit_q <= hit ? so_bit : 1'b0;
         else if (hit)  bit_q <= so_bit;
      end
      assign cap[g] = bit_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dout_q <= '0;
      else if (publish) dout_q <= cap;
   end

   assign si   = shifting ? din_q[cur_idx] : 1'b0;
   assign dout = dout_q;
endmodule

// File: rtl/scan2ph_pins.sv
module scan2ph_pins
   import scan2ph_pkg::*;
#(
   parameter bit REG = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  ctl_st_e st_i,
   input  seg_e    sg_i,
   output logic    phi1,
   output logic    phi2,
   output logic    rd,
   output logic    wr
);
   pins_t p;
   assign p = pins_of(st_i, sg_i);

   if (REG) begin : g_reg
      pins_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= PINS_IDLE;
         else        q <= p;
      end
      assign phi1 = q.phi1;
      assign phi2 = q.phi2;
      assign rd   = q.rd;
      assign wr   = q.wr;
   end else begin : g_comb
      assign phi1 = p.phi1;
      assign phi2 = p.phi2;
      assign rd   = p.rd;
      assign wr   = p.wr;
   end
endmodule

// File: rtl/scan2ph_ctrl.sv
module scan2ph_ctrl
   import scan2ph_pkg::*;
#(
   parameter int MAX_LEN  = 64,
   parameter int T_LEAD   = 9,
   parameter int T_GAP    = 1,
   parameter int T_PHI1   = 19,
   parameter int T_TAIL   = 10,
   parameter int T_STB_HI = 80,
   parameter int T_STB_LO = 40,
   parameter bit REG_PINS = 1'b1,
   localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LEN_W-1:0]   cmd_len,
   input  logic [MAX_LEN-1:0] cmd_din,
   input  logic               cmd_rd,
   input  logic               cmd_wr,
   output logic               busy,
   output logic               done,
   output logic [MAX_LEN-1:0] dout,
   output logic               scan_phi1,
   output logic               scan_phi2,
   output logic               scan_rd,
   output logic               scan_wr,
   output logic               scan_si,
   input  logic               scan_so
);
   localparam int IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
   localparam int T_SUM = T_LEAD + 2 * T_GAP + T_PHI1 + T_TAIL + T_STB_HI + T_STB_LO;
   localparam int TK_W  = $clog2(T_SUM + 1);

   if (MAX_LEN < 1) begin : g_bad_len
      $error("MAX_LEN must be at least 1");
   end
   if (T_GAP < 1) begin : g_bad_gap
      $error("T_GAP must be at least 1 to keep the phases apart");
   end
   if (T_LEAD < 1 || T_PHI1 < 1 || T_TAIL < 1 || T_STB_HI < 1 || T_STB_LO < 1) begin : g_bad_seg
      $error("every timing segment needs at least one tick");
   end

   ctl_st_e          st_q, st_n;
   seg_e             sg_q, sg_n;
   logic [IDX_W-1:0] idx_q, idx_n;
   logic             wr_q, done_q;
   logic             tk_load, tk_zero;
   logic [TK_W-1:0]  tk_val;
   logic             cap_en, accept, finish, len_ok;

   assign len_ok = (cmd_len != '0) && (cmd_len <= LEN_W'(MAX_LEN));

   scan2ph_tick #(.W(TK_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tk_load),
      .load_val(tk_val),
      .zero    (tk_zero)
   );

   always_comb begin
      st_n    = st_q;
      sg_n    = sg_q;
      idx_n   = idx_q;
      tk_load = 1'b0;
      tk_val  = '0;
      cap_en  = 1'b0;
      accept  = 1'b0;
      finish  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start && len_ok) begin
               accept = 1'b1;
               idx_n  = IDX_W'(cmd_len - LEN_W'(1));
               tk_load = 1'b1;
               if (cmd_rd) begin
                  st_n   = ST_RD_HI;
                  tk_val = TK_W'(T_STB_HI - 1);
               end else begin
                  st_n   = ST_SHIFT;
                  sg_n   = SG_LEAD;
                  tk_val = TK_W'(T_LEAD - 1);
                  cap_en = 1'b1;
               end
            end
         end
         ST_RD_HI: if (tk_zero) begin
            st_n    = ST_RD_LO;
            tk_load = 1'b1;
            tk_val  = TK_W'(T_STB_LO - 1);
         end
         ST_RD_LO: if (tk_zero) begin
            st_n    = ST_SHIFT;
            sg_n    = SG_LEAD;
            tk_load = 1'b1;
            tk_val  = TK_W'(T_LEAD - 1);
            cap_en  = 1'b1;
         end
         ST_SHIFT: if (tk_zero) begin
            tk_load = 1'b1;
            unique case (sg_q)
               SG_LEAD: begin sg_n = SG_FALL; tk_val = TK_W'(T_GAP - 1);  end
               SG_FALL: begin sg_n = SG_PHI1; tk_val = TK_W'(T_PHI1 - 1); end
               SG_PHI1: begin sg_n = SG_RISE; tk_val = TK_W'(T_GAP - 1);  end
               SG_RISE: begin sg_n = SG_TAIL; tk_val = TK_W'(T_TAIL - 1); end
               default: begin
                  sg_n = SG_LEAD;
                  if (idx_q != '0) begin
                     idx_n  = idx_q - IDX_W'(1);
                     tk_val = TK_W'(T_LEAD - 1);
                     cap_en = 1'b1;
                  end else if (wr_q) begin
                     st_n   = ST_WR_HI;
                     tk_val = TK_W'(T_STB_HI - 1);
                  end else begin
                     st_n    = ST_IDLE;
                     tk_load = 1'b0;
                     finish  = 1'b1;
                  end
               end
            endcase
         end
         ST_WR_HI: if (tk_zero) begin
            st_n    = ST_WR_LO;
            tk_load = 1'b1;
            tk_val  = TK_W'(T_STB_LO - 1);
         end
         ST_WR_LO: if (tk_zero) begin
            st_n   = ST_IDLE;
            finish = 1'b1;
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         sg_q   <= SG_LEAD;
         idx_q  <= '0;
         wr_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_n;
         sg_q   <= sg_n;
         idx_q  <= idx_n;
         done_q <= finish;
         if (accept) wr_q <= cmd_wr;
      end
   end

   scan2ph_capture #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .load_din(cmd_din),
      .cap_en  (cap_en),
      .cap_idx (idx_n),
      .cur_idx (idx_q),
      .shifting(st_q == ST_SHIFT),
      .publish (finish),
      .so      (scan_so),
      .si      (scan_si),
      .dout    (dout)
   );

   if (REG_PINS) begin : g_pins_reg
      scan2ph_pins #(.REG(1'b1)) u_pins (
         .clk(clk), .rst_n(rst_n), .st_i(st_n), .sg_i(sg_n),
         .phi1(scan_phi1), .phi2(scan_phi2), .rd(scan_rd), .wr(scan_wr)
      );
   end else begin : g_pins_comb
      scan2ph_pins #(.REG(1'b0)) u_pins (
         .clk(clk), .rst_n(rst_n), .st_i(st_q), .sg_i(sg_q),
         .phi1(scan_phi1), .phi2(scan_phi2), .rd(scan_rd), .wr(scan_wr)
      );
   end

   assign busy = (st_q != ST_IDLE);
   assign done = done_q;

   assert_phase_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(scan_phi1 && scan_phi2));
   assert_phi1_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scan_phi1) |-> !$past(scan_phi2));
   assert_phi2_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scan_phi2) |-> !$past(scan_phi1));
   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   assert_strobe_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_rd || scan_wr) |-> (scan_phi2 && !scan_phi1 && !(scan_rd && scan_wr)));
   assert_si_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !scan_si);
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_dout_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(dout));
endmodule

// File: tb/scan2ph_ctrl_tb.sv
module scan2ph_ctrl_tb_top;
   localparam int ML = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [6:0]    cmd_len = '0;
   logic [ML-1:0] cmd_din = '0;
   logic          cmd_rd = 1'b0, cmd_wr = 1'b0;
   logic          busy, done, scan_phi1, scan_phi2, scan_rd, scan_wr, scan_si;
   logic          scan_so = 1'b0;
   logic [ML-1:0] dout;

   int checks = 0, fails = 0, cyc = 0, accepts = 0;
   bit so_hold = 1'b0;

   always #5 clk = ~clk;

   scan2ph_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len), .cmd_din(cmd_din),
      .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .busy(busy), .done(done), .dout(dout),
      .scan_phi1(scan_phi1), .scan_phi2(scan_phi2), .scan_rd(scan_rd), .scan_wr(scan_wr),
      .scan_si(scan_si), .scan_so(scan_so)
   );

   typedef struct {
      bit busy, done, phi1, phi2, rd, wr, si;
      int cap;
   } ent_t;

   ent_t q[$];
   ent_t cur;
   logic [ML-1:0] m_cap, m_dout;

   function automatic ent_t mk(bit b, bit d, bit p1, bit p2, bit r, bit w, bit s, int c);
      ent_t e;
      e.busy = b; e.done = d; e.phi1 = p1; e.phi2 = p2;
      e.rd = r; e.wr = w; e.si = s; e.cap = c;
      return e;
   endfunction

   task automatic build(int len, logic [ML-1:0] din, bit rd, bit wr);
      if (rd) begin
         repeat (80) q.push_back(mk(1, 0, 0, 1, 1, 0, 0, -1));
         repeat (40) q.push_back(mk(1, 0, 0, 1, 0, 0, 0, -1));
      end
      for (int i = len - 1; i >= 0; i--)
         for (int t = 0; t < 40; t++)
            q.push_back(mk(1, 0, (t >= 10 && t < 29), (t < 9 || t >= 30), 0, 0,
                           din[i], (t == 0) ? i : -1));
      if (wr) begin
         repeat (80) q.push_back(mk(1, 0, 0, 1, 0, 1, 0, -1));
         repeat (40) q.push_back(mk(1, 0, 0, 1, 0, 0, 0, -1));
      end
      q.push_back(mk(0, 1, 0, 1, 0, 0, 0, -1));
   endtask

   // Reference timeline: one entry per cycle, popped at each rising edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         q.delete();
         cur = mk(0, 0, 0, 1, 0, 0, 0, -1);
         m_dout = '0;
         m_cap = '0;
      end else begin
         if (q.size() == 0 && start && cmd_len >= 1 && cmd_len <= ML) begin
            build(int'(cmd_len), cmd_din, cmd_rd, cmd_wr);
            m_cap = '0;
            accepts++;
         end
         if (q.size() != 0) begin
            cur = q.pop_front();
            if (cur.cap >= 0) m_cap[cur.cap] = scan_so;
            if (cur.done) m_dout = m_cap;
         end else begin
            cur = mk(0, 0, 0, 1, 0, 0, 0, -1);
         end
      end
   end

   initial forever begin
      @(negedge clk);
      scan_so = so_hold ? 1'b1 : (cyc[0] ^ cyc[3] ^ cyc[6]);
   end

   task automatic chk(bit ok, string tag, string what, logic [ML-1:0] act, logic [ML-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
      end
   endtask

   initial forever begin
      @(negedge clk);
      if (rst_n) begin
         chk(busy == cur.busy, "R2", "busy", ML'(busy), ML'(cur.busy));
         chk(done == cur.done, "R8", "done", ML'(done), ML'(cur.done));
         chk(scan_phi1 == cur.phi1, "R3", "phi1", ML'(scan_phi1), ML'(cur.phi1));
         chk(scan_phi2 == cur.phi2, "R3", "phi2", ML'(scan_phi2), ML'(cur.phi2));
         chk(scan_rd == cur.rd, "R4", "rd strobe", ML'(scan_rd), ML'(cur.rd));
         chk(scan_wr == cur.wr, "R7", "wr strobe", ML'(scan_wr), ML'(cur.wr));
         chk(scan_si == cur.si, "R5", "scan in", ML'(scan_si), ML'(cur.si));
         chk(dout === m_dout, "R6 R9", "dout", dout, m_dout);
      end
   end

   task automatic wait_idle();
      do @(negedge clk); while (q.size() != 0);
      @(negedge clk);
   endtask

   task automatic run_cmd(int len, logic [ML-1:0] din, bit rd, bit wr);
      @(negedge clk);
      start = 1'b1; cmd_len = 7'(len); cmd_din = din; cmd_rd = rd; cmd_wr = wr;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle levels after reset
      chk(scan_phi2 && !scan_phi1 && !scan_rd && !scan_wr && !scan_si && !busy && !done,
          "R1", "idle pins", ML'({scan_phi1, scan_phi2, scan_rd, scan_wr, scan_si, busy, done}),
          ML'(7'b0100000));
      chk(dout == '0, "R1", "reset dout", dout, '0);

      // R5 R6: single bit, no strobes
      run_cmd(1, 64'h1, 0, 0);
      // R4 R7: both strobes, short chain
      run_cmd(5, 64'h15, 1, 1);
      // R8: full length with update only
      run_cmd(ML, 64'hA5C3_0F96_3C5A_E127, 0, 1);
      // R6: constant high return line
      so_hold = 1'b1;
      run_cmd(7, 64'h0, 1, 0);
      so_hold = 1'b0;
      // R2: zero and oversize lengths are ignored
      run_cmd(0, 64'hFF, 1, 1);
      chk(!busy, "R2", "zero length ignored", ML'(busy), '0);
      run_cmd(ML + 1, 64'hFF, 0, 0);
      chk(!busy, "R2", "oversize length ignored", ML'(busy), '0);
      // R2: start while busy is ignored
      @(negedge clk);
      start = 1'b1; cmd_len = 7'd3; cmd_din = 64'h6; cmd_rd = 0; cmd_wr = 0;
      @(negedge clk);
      start = 1'b0;
      repeat (50) @(negedge clk);
      start = 1'b1; cmd_len = 7'd9; cmd_din = 64'h1FF; cmd_rd = 1; cmd_wr = 1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
      // R8 R9: start held across completion, next command taken in the done cycle
      begin
         int a0;
         a0 = accepts;
         @(negedge clk);
         start = 1'b1; cmd_len = 7'd4; cmd_din = 64'hB; cmd_rd = 0; cmd_wr = 1;
         while (accepts < a0 + 2) @(negedge clk);
         start = 1'b0;
         chk(accepts == a0 + 2, "R8", "back-to-back accepts", ML'(accepts - a0), ML'(2));
         wait_idle();
      end
      repeat (5) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule